// File: doc/BRIEF.md
# Polled Byte Reader Controller

This block is a peripheral controller that sits on a simple single-cycle system bus with an 8-bit address. It claims a contiguous, aligned window of eight addresses. Inside that window four byte-wide registers carry a polled handshake between the CPU and a byte source. The CPU side owns a command register and its own status register. The device side owns a status register and a data register. An address decoder raises a device-active flag for the window and drives a memory-enable output low for those addresses, so main memory stays off the bus while the controller answers.

The CPU arms the device with the START command and then writes the "go" code into its status register. After a programmable fetch delay, the device loads the next byte from a counter-based pattern source into its data register and raises "ready" in its own status register. The CPU polls that status, reads the byte, and writes the "accepted" code. The device then drops its status back to idle and starts fetching the following byte. Bus reads are combinational: read data is valid in the same cycle that read enable and device-active are both high.

Top module: `byte_reader_ctrl`

## Requirements
- R1: `devActive` is high exactly when `busAddr` lies in the window 128..135 (BASE_ADDR=128, WIN_WORDS=8).
- R2: `memEnable` is low exactly when the address is inside the window, and high for every other address.
- R3: With `busRe` high inside the window, `busRdata` returns the CPU status at offset 0 (address 128), the device status at offset 1 (129), the command at offset 2 (130), the data register at offset 3 (131), and 0 at offsets 4..7 (132..135), all in the same cycle. Outside a window read, `busRdata` is 0.
- R4: A write inside the window stores the whole byte into the CPU status (128) or command (130) register. Writes to 129, 131, 132..135 and all writes outside the window leave every register unchanged.
- R5: Once the command register holds 8'h01 (START) and the CPU status holds 8'h01 (go), the device status becomes 8'h01 (ready) and the data register holds a new byte FETCH_DELAY+1 rising edges after the write edge that completed the condition.
- R6: Without the START command, a go code in the CPU status has no effect, and the device status stays 8'h00.
- R7: The k-th byte delivered since reset (k from 0) is (SEED + k*STEP) mod 256. With the defaults 8'h5A and 8'h11 this gives 5A, 6B, 7C, and so on.
- R8: A write of 8'h02 (accepted) to address 128 while the device status is ready clears it to 8'h00 at that edge. The next byte is ready FETCH_DELAY edges after that write. An accepted write while the device is still fetching does not change when the byte becomes ready.
- R9: The data register keeps its byte, including after an accepted write, until the next byte is loaded.
- R10: A synchronous active-high reset clears all four registers and the pattern source to their initial state and returns the handshake to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Bus address |
| busWe | input | 1 | Bus write enable |
| busRe | input | 1 | Bus read enable |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data, valid in the cycle of the read |
| devActive | output | 1 | High when the address hits the controller window |
| memEnable | output | 1 | Low for window addresses so main memory ignores them |

## Verification
Every cycle, the assertions check the window decode against an arithmetic range compare and confirm that memory enable is the inverse of a hit. They also check that read data is zero when no window read is active, that the fetch counter stays inside its bound, that an accepted write moves the handshake back to fetching, that an unarmed controller stays idle, and that the data register holds steady while ready persists. The following can only be shown by the bench's scenarios: the exact ready latency after a go write and after an accepted write, the predicted byte sequence, the ignoring of writes to device-owned and unused addresses, and the clean restart after a mid-transfer reset.

// File: rtl/brd_pkg.sv
package brd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic loadByte;
    logic setReady;
    logic clrReady;
  } ctlStrobe_t;

  localparam logic [7:0] CMD_START  = 8'h01;
  localparam logic [7:0] CPU_GO     = 8'h01;
  localparam logic [7:0] CPU_ACK    = 8'h02;
  localparam logic [7:0] DEV_IDLE   = 8'h00;
  localparam logic [7:0] DEV_READY  = 8'h01;

  localparam int OFF_CPU_STAT = 0;
  localparam int OFF_DEV_STAT = 1;
  localparam int OFF_CMD      = 2;
  localparam int OFF_DATA     = 3;

endpackage

// File: rtl/brd_decode.sv
module brd_decode #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 128,
  parameter int WIN_WORDS = 8,
  localparam int OFF_W    = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  output logic              devActive,
  output logic              memEnable,
  output logic [OFF_W-1:0]  regOffset
);

  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);

  // Aligned window: compare only the bits above the offset field.
  assign devActive = (busAddr[ADDR_W-1:OFF_W] == BASE_VEC[ADDR_W-1:OFF_W]);
  assign memEnable = !devActive;
  assign regOffset = busAddr[OFF_W-1:0];

endmodule

// File: rtl/brd_control.sv
module brd_control
  import brd_pkg::*;
#(
  parameter int FETCH_DELAY = 4,
  localparam int CNT_W      = (FETCH_DELAY > 1) ? $clog2(FETCH_DELAY) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdStart,
  input  logic       goReq,
  input  logic       ackWrite,
  output ctlStrobe_t strobes
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FETCH_DELAY - 1);

  ctlState_t state;
  logic [CNT_W-1:0] fetchCnt;
  logic fetchDone;

  assign fetchDone = (state == ST_FETCH) && (fetchCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fetchCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdStart && goReq) begin
            state    <= ST_FETCH;
            fetchCnt <= '0;
          end
        end
        ST_FETCH: begin
          if (fetchCnt == LAST) state <= ST_WAIT;
          else                  fetchCnt <= fetchCnt + 1'b1;
        end
        ST_WAIT: begin
          if (ackWrite) begin
            state    <= ST_FETCH;
            fetchCnt <= '0;
          end
        end
        default: begin
          state    <= ST_IDLE;
          fetchCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobes.loadByte = fetchDone;
    strobes.setReady = fetchDone;
    strobes.clrReady = (state == ST_WAIT) && ackWrite;
  end

  // R5: the fetch counter never passes the programmed delay
  assert_fetch_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (int'(fetchCnt) < FETCH_DELAY));

  // R8: an accepted write while waiting restarts a fetch from zero
  assert_ack_refetch_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && ackWrite) |=> (state == ST_FETCH && fetchCnt == '0));

  // R6: without START the handshake never leaves idle
  assert_idle_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cmdStart) |=> (state == ST_IDLE));

endmodule

// File: rtl/brd_datapath.sv
module brd_datapath
  import brd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3,
  parameter logic [DATA_W-1:0] SEED = 8'h5A,
  parameter logic [DATA_W-1:0] STEP = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              devActive,
  input  logic [OFF_W-1:0]  regOffset,
  input  logic [DATA_W-1:0] busWdata,
  input  ctlStrobe_t        strobes,
  output logic [DATA_W-1:0] busRdata,
  output logic              cmdStart,
  output logic              goReq,
  output logic              ackWrite
);

  logic [DATA_W-1:0] cpuStat, cmdReg, devStat, dataReg, nextByte;
  logic wrCpuStat, wrCmd;

  assign wrCpuStat = busWe && devActive && (regOffset == OFF_W'(OFF_CPU_STAT));
  assign wrCmd     = busWe && devActive && (regOffset == OFF_W'(OFF_CMD));

  assign cmdStart = (cmdReg == DATA_W'(CMD_START));
  assign goReq    = (cpuStat == DATA_W'(CPU_GO));
  assign ackWrite = wrCpuStat && (busWdata == DATA_W'(CPU_ACK));

  // CPU-owned registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cpuStat <= '0;
      cmdReg  <= '0;
    end else begin
      if (wrCpuStat) cpuStat <= busWdata;
      if (wrCmd)     cmdReg  <= busWdata;
    end
  end

  // Device-owned registers and the pattern source
  always_ff @(posedge clk) begin
    if (rst) begin
      devStat  <= DATA_W'(DEV_IDLE);
      dataReg  <= '0;
      nextByte <= SEED;
    end else begin
      if (strobes.clrReady)      devStat <= DATA_W'(DEV_IDLE);
      else if (strobes.setReady) devStat <= DATA_W'(DEV_READY);
      if (strobes.loadByte) begin
        dataReg  <= nextByte;
        nextByte <= nextByte + STEP;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRe && devActive) begin
      case (int'(regOffset))
        OFF_CPU_STAT: busRdata = cpuStat;
        OFF_DEV_STAT: busRdata = devStat;
        OFF_CMD:      busRdata = cmdReg;
        OFF_DATA:     busRdata = dataReg;
        default:      busRdata = '0;
      endcase
    end
  end

  // R3: no window read means a quiet read bus
  assert_rdata_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(busRe && devActive) |-> (busRdata == '0));

  // R9: while ready persists the delivered byte does not move
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (devStat == DATA_W'(DEV_READY) && $past(devStat) == DATA_W'(DEV_READY))
      |-> $stable(dataReg));

  // R4: a bus write to the data address never alters it
  assert_data_ro_R4: assert property (@(posedge clk) disable iff (rst)
    (busWe && devActive && regOffset == OFF_W'(OFF_DATA) && !strobes.loadByte)
      |=> $stable(dataReg));

endmodule

// File: rtl/byte_reader_ctrl.sv
module byte_reader_ctrl
  import brd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int BASE_ADDR   = 128,
  parameter int WIN_WORDS   = 8,
  parameter int FETCH_DELAY = 4,
  parameter logic [DATA_W-1:0] SEED = 8'h5A,
  parameter logic [DATA_W-1:0] STEP = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              devActive,
  output logic              memEnable
);

  localparam int OFF_W = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;

  logic [OFF_W-1:0] regOffset;
  logic cmdStart, goReq, ackWrite;
  ctlStrobe_t strobes;

  brd_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS)) uDecode (
    .busAddr(busAddr), .devActive(devActive), .memEnable(memEnable), .regOffset(regOffset)
  );

  brd_control #(.FETCH_DELAY(FETCH_DELAY)) uControl (
    .clk(clk), .rst(rst), .cmdStart(cmdStart), .goReq(goReq),
    .ackWrite(ackWrite), .strobes(strobes)
  );

  brd_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SEED(SEED), .STEP(STEP)) uDatapath (
    .clk(clk), .rst(rst), .busWe(busWe), .busRe(busRe), .devActive(devActive),
    .regOffset(regOffset), .busWdata(busWdata), .strobes(strobes),
    .busRdata(busRdata), .cmdStart(cmdStart), .goReq(goReq), .ackWrite(ackWrite)
  );

  // R1: a hit means the address lies inside the numeric window
  assert_window_R1: assert property (@(posedge clk) disable iff (rst)
    devActive |-> (int'(busAddr) >= BASE_ADDR && int'(busAddr) < BASE_ADDR + WIN_WORDS));

  // R2: memory is enabled exactly for addresses outside the window
  assert_mem_excl_R2: assert property (@(posedge clk) disable iff (rst)
    memEnable == (int'(busAddr) < BASE_ADDR || int'(busAddr) >= BASE_ADDR + WIN_WORDS));

endmodule

// File: tb/sim_byte_reader_ctrl.sv
module sim_byte_reader_ctrl;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0;
  logic busRe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic devActive, memEnable;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  byte_reader_ctrl u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .devActive(devActive), .memEnable(memEnable)
  );

  function automatic logic [7:0] expByte(int k);
    return 8'(32'h5A + k * 32'h11);
  endfunction

  function automatic logic inWin(logic [7:0] a);
    return (a >= 8'd128) && (a <= 8'd135);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; busRe = 1'b0;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  // call right after a falling edge
  task automatic readAt(logic [7:0] a, output logic [7:0] v);
    busWe = 1'b0; busAddr = a; busRe = 1'b1;
    #1 v = busRdata;
  endtask

  // call just after the edge that started the wait
  task automatic readyAfter(int edges, string req);
    logic [7:0] v;
    if (edges > 1) repeat (edges - 1) @(posedge clk);
    @(negedge clk); readAt(8'd129, v);
    chk(req, "status one edge early", v, 8'h00);
    @(negedge clk); readAt(8'd129, v);
    chk(req, "status at ready edge", v, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, a;
    int k;
    void'($urandom(32'hC0FFEE));

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: reset state
    for (int i = 128; i < 132; i++) begin
      @(negedge clk); readAt(8'(i), v);
      chk("R10", "register after reset", v, 0);
    end

    // R6: go without START does nothing
    busWrite(8'd128, 8'h01);
    repeat (N + 3) @(posedge clk);
    @(negedge clk); readAt(8'd129, v);
    chk("R6", "status unarmed", v, 8'h00);

    // R4: ignored writes to device-owned, unused and outside addresses
    for (int i = 0; i < 30; i++) begin
      case ($urandom_range(0, 2))
        0: a = 8'd129;
        1: a = 8'(131 + $urandom_range(0, 4));
        default: begin
          a = 8'($urandom);
          while (inWin(a)) a = 8'($urandom);
        end
      endcase
      busWrite(a, 8'($urandom));
    end
    @(negedge clk); readAt(8'd128, v); chk("R4", "cpu status kept", v, 8'h01);
    @(negedge clk); readAt(8'd129, v); chk("R4", "dev status kept", v, 8'h00);
    @(negedge clk); readAt(8'd130, v); chk("R4", "command kept", v, 8'h00);
    @(negedge clk); readAt(8'd131, v); chk("R4", "data kept", v, 8'h00);

    // R5, R7: arm with START, first byte after N+1 edges
    busWrite(8'd130, 8'h01);
    readyAfter(N + 1, "R5");
    readAt(8'd131, v); chk("R7", "byte 0", v, expByte(0));
    @(negedge clk); readAt(8'd130, v); chk("R3", "command readback", v, 8'h01);

    // R1 boundary: write just above the window is not an ack
    busWrite(8'd136, 8'h02);
    @(negedge clk); readAt(8'd129, v); chk("R1", "status after out-of-window write", v, 8'h01);

    // R8, R9, R7: several bytes with random pauses before acceptance
    for (k = 1; k <= 6; k++) begin
      repeat ($urandom_range(0, 5)) begin
        @(negedge clk); readAt(8'd131, v);
        chk("R9", "byte held while ready", v, expByte(k - 1));
      end
      busWrite(8'd128, 8'h02);
      @(negedge clk); readAt(8'd129, v); chk("R8", "status cleared by accept", v, 8'h00);
      readAt(8'd131, v); chk("R9", "byte held after accept", v, expByte(k - 1));
      readyAfter(N, "R8");
      readAt(8'd131, v); chk("R7", "next byte", v, expByte(k));
    end

    // R8: an accept during fetch does not shift the ready edge
    busWrite(8'd128, 8'h02);
    busWrite(8'd128, 8'h02);
    readyAfter(N - 1, "R8");
    readAt(8'd131, v); chk("R7", "byte after double accept", v, expByte(7));

    // R3: unused window offsets read zero, status readback
    for (int i = 132; i < 136; i++) begin
      @(negedge clk); readAt(8'(i), v);
      chk("R3", "unused offset", v, 0);
    end
    @(negedge clk); readAt(8'd128, v); chk("R3", "cpu status readback", v, 8'h02);

    // R10: reset mid-transfer, then a clean restart from the seed
    busWrite(8'd128, 8'h02);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 128; i < 132; i++) begin
      @(negedge clk); readAt(8'(i), v);
      chk("R10", "register after mid reset", v, 0);
    end
    busWrite(8'd130, 8'h01);
    busWrite(8'd128, 8'h01);
    readyAfter(N + 1, "R5");
    readAt(8'd131, v); chk("R10", "pattern restarted", v, expByte(0));

    // R1, R2, R3: random decode sweep plus both window edges
    for (int i = 0; i < 40; i++) begin
      if (i == 0) a = 8'd127;
      else if (i == 1) a = 8'd135;
      else a = 8'($urandom);
      @(negedge clk);
      busRe = ($urandom_range(0, 1) == 1);
      busAddr = a;
      #1;
      chk("R1", "devActive", int'(devActive), int'(inWin(a)));
      chk("R2", "memEnable", int'(memEnable), int'(!inWin(a)));
      if (!inWin(a) || !busRe) chk("R3", "idle read bus", busRdata, 0);
    end

    busRe = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule